// File: doc/BRIEF.md
# Isochronous Transmit Context Sequencer

Once per isochronous bus cycle this block collects outgoing packets for a small set of transmit contexts and places them in a transmit FIFO. Each context has its own enable bit and descriptor pointer, and software controls both. A cycle-start strobe makes the sequencer visit the contexts in ascending index order. It skips a context whose enable bit is low. For an enabled context it fetches a two-word descriptor, works out the payload length and address, and then fetches the payload one word at a time. Every payload word is written into the FIFO.

After the last context the sequencer writes a tagged marker word. The consumer uses it to know that the cycle's data has ended. All memory traffic goes through a single-word request/grant read port. FIFO back-pressure stalls the sequencer in place. A cycle start that arrives while a cycle is still being processed is counted and otherwise dropped.

Top module: `isoc_tx_seq`

## Requirements
- R1: After reset the sequencer is idle: `mem_req` is 0, `fifo_wr` is 0 and `ovr_cnt` is 0.
- R2: A cycle start received while idle walks the contexts in index order, 0 first, and fetches at most one packet for each enabled context in that cycle.
- R3: A context whose `ctx_en` bit is 0 produces no memory access during that cycle.
- R4: `mem_req` and `mem_addr` stay stable until `mem_gnt` is seen. Each grant reads exactly one word, which arrives later with `mem_rvalid`.
- R5: The descriptor is read from the context pointer P (byte count) and then from P+4 (payload byte address). Only bits 15:0 of the first word count. The payload is then read from address A, A+4, A+8 and so on.
- R6: The payload byte count is rounded up to whole 32-bit words. A count of 0 gives no payload read and no FIFO write for that context.
- R7: Each use of a context's descriptor advances its pointer by 8. A `ptr_load[i]` pulse sets pointer i to `ptr_wdata`.
- R8: Payload words are written to the FIFO in fetch order with `fifo_tag`=0. After the last context, one word equal to `MARK_WORD` is written with `fifo_tag`=1. This also happens when no context is enabled.
- R9: While `fifo_full` is 1 no FIFO write happens. The pending word is held and written later, so no data is lost.
- R10: A cycle start that arrives while a cycle is in progress increments `ovr_cnt` by one and starts no extra cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctx_en | input | NCTX (4) | Per-context enable |
| ptr_load | input | NCTX (4) | Per-context descriptor-pointer write strobe |
| ptr_wdata | input | AW (32) | Pointer value to load |
| cyc_start | input | 1 | Isochronous cycle-start strobe |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | AW (32) | Byte address of the word requested |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW (32) | Read data |
| fifo_full | input | 1 | FIFO cannot accept a word |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | DW (32) | FIFO write word |
| fifo_tag | output | 1 | 1 marks the end-of-cycle marker word |
| ovr_cnt | output | 8 | Count of overrun cycle starts (wraps) |

## Verification
The bench computes the full read-address sequence and the FIFO word stream for each cycle, so state faults show up at the ports of the affected cycle. A wrong context index or a bad pointer step shows as a wrong descriptor address at the next grant. A wrong word count shows as extra or missing payload reads before the marker. A stall that drops data shows as a mismatch in the FIFO stream. The bench sweeps every enable mask under varied grant delays and FIFO-full patterns. A fault that carries state across cycles, such as pointer advance or overrun handling, shows within one cycle start.

// File: rtl/isoc_tx_seq.sv
module isoc_tx_seq #(
  parameter int          NCTX      = 4,
  parameter int          AW        = 32,
  parameter int          DW        = 32,
  parameter int          LENW      = 16,
  parameter logic [31:0] MARK_WORD = 32'hC0DE_CAFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCTX-1:0] ctx_en,
  input  logic [NCTX-1:0] ptr_load,
  input  logic [AW-1:0]   ptr_wdata,
  input  logic            cyc_start,
  output logic            mem_req,
  output logic [AW-1:0]   mem_addr,
  input  logic            mem_gnt,
  input  logic            mem_rvalid,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            fifo_full,
  output logic            fifo_wr,
  output logic [DW-1:0]   fifo_data,
  output logic            fifo_tag,
  output logic [7:0]      ovr_cnt
);
  localparam int CW  = (NCTX > 1) ? $clog2(NCTX) : 1;
  localparam int NWW = LENW - 1;

  typedef enum logic [2:0] {S_IDLE, S_SCAN, S_REQ, S_WAIT, S_PUSH, S_MARK} st_t;

  st_t            st;
  logic [CW-1:0]  ctx;
  logic           is_pay;
  logic [NWW-1:0] widx, nwords;
  logic [AW-1:0]  pay_addr;
  logic [DW-1:0]  hold;
  logic [AW-1:0]  ptr [NCTX];
  logic [LENW:0]  rnd;
  logic           last, adv, busy;

  assign busy      = (st != S_IDLE);
  assign last      = (ctx == CW'(NCTX - 1));
  assign rnd       = {1'b0, mem_rdata[LENW-1:0]} + (LENW+1)'(3);
  assign adv       = (st == S_WAIT) && mem_rvalid && !is_pay && widx[0];
  assign mem_req   = (st == S_REQ);
  assign mem_addr  = (is_pay ? pay_addr : ptr[ctx]) + AW'({widx, 2'b00});
  assign fifo_wr   = ((st == S_PUSH) || (st == S_MARK)) && !fifo_full;
  assign fifo_tag  = (st == S_MARK);
  assign fifo_data = (st == S_MARK) ? DW'(MARK_WORD) : hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCTX; i++) ptr[i] <= '0;
    end else begin
      for (int i = 0; i < NCTX; i++) begin
        if (ptr_load[i])                  ptr[i] <= ptr_wdata;
        else if (adv && ctx == CW'(i))    ptr[i] <= ptr[i] + AW'(8);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_cnt <= '0;
    end else if (cyc_start && busy) begin
      ovr_cnt <= ovr_cnt + 8'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ctx      <= '0;
      is_pay   <= 1'b0;
      widx     <= '0;
      nwords   <= '0;
      pay_addr <= '0;
      hold     <= '0;
    end else begin
      case (st)
        S_IDLE: if (cyc_start) begin
          ctx <= '0;
          st  <= S_SCAN;
        end
        S_SCAN: begin
          if (ctx_en[ctx]) begin
            is_pay <= 1'b0;
            widx   <= '0;
            st     <= S_REQ;
          end else if (last) st <= S_MARK;
          else ctx <= ctx + 1'b1;
        end
        S_REQ: if (mem_gnt) st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          if (is_pay) begin
            hold <= mem_rdata;
            st   <= S_PUSH;
          end else if (!widx[0]) begin
            nwords <= rnd[LENW:2];
            widx   <= NWW'(1);
            st     <= S_REQ;
          end else begin
            pay_addr <= AW'(mem_rdata);
            widx     <= '0;
            if (nwords != '0) begin
              is_pay <= 1'b1;
              st     <= S_REQ;
            end else if (last) st <= S_MARK;
            else begin
              ctx <= ctx + 1'b1;
              st  <= S_SCAN;
            end
          end
        end
        S_PUSH: if (!fifo_full) begin
          if (widx != nwords - 1'b1) begin
            widx <= widx + 1'b1;
            st   <= S_REQ;
          end else if (last) st <= S_MARK;
          else begin
            ctx <= ctx + 1'b1;
            st  <= S_SCAN;
          end
        end
        S_MARK: if (!fifo_full) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module isoc_tx_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          cyc_start,
  input logic          mem_req,
  input logic [AW-1:0] mem_addr,
  input logic          mem_gnt,
  input logic          fifo_full,
  input logic          fifo_wr,
  input logic          fifo_tag,
  input logic [7:0]    ovr_cnt
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_req && !fifo_wr));                                   // R1
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));           // R4
  AST_MARK_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_tag) |=> !fifo_wr);                                 // R8
  AST_NO_WR_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full |-> !fifo_wr);                                             // R9
  AST_OVR_INC: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && busy) |=> (ovr_cnt == $past(ovr_cnt) + 8'd1));         // R10
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(cyc_start && busy) |=> $stable(ovr_cnt));                          // R10
endmodule

bind isoc_tx_seq isoc_tx_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .cyc_start(cyc_start),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt),
  .fifo_full(fifo_full), .fifo_wr(fifo_wr), .fifo_tag(fifo_tag),
  .ovr_cnt(ovr_cnt)
);

// File: tb/tb_isoc_tx_seq.sv
module tb_isoc_tx_seq;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MARK = 32'hC0DE_CAFE;

  logic        clk = 0, rst_n = 0;
  logic [3:0]  ctx_en = 0, ptr_load = 0;
  logic [31:0] ptr_wdata = 0;
  logic        cyc_start = 0;
  logic        mem_req, mem_gnt = 0, mem_rvalid = 0;
  logic [31:0] mem_addr, mem_rdata = 0;
  logic        fifo_full = 0, fifo_wr, fifo_tag;
  logic [31:0] fifo_data;
  logic [7:0]  ovr_cnt;

  isoc_tx_seq dut (
    .clk(clk), .rst_n(rst_n), .ctx_en(ctx_en), .ptr_load(ptr_load),
    .ptr_wdata(ptr_wdata), .cyc_start(cyc_start), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .fifo_full(fifo_full), .fifo_wr(fifo_wr),
    .fifo_data(fifo_data), .fifo_tag(fifo_tag), .ovr_cnt(ovr_cnt)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] mem [256];
  logic [31:0] acc_log [64];
  logic [31:0] fd_log [64];
  logic        ft_log [64];
  int n_acc, n_fifo;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int gnt_mode = 0, lat = 1, full_mode = 0;
  int gcnt = 0, fcnt = 0, pcnt = 0;
  bit pend = 0;
  logic [7:0] paddr, gaddr;
  logic [31:0] ptr_m [4];

  always @(negedge clk) begin
    mem_rvalid = 0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rvalid = 1; mem_rdata = mem[paddr]; pend = 0;
      end else pcnt--;
    end
    if (mem_gnt) begin pend = 1; pcnt = lat - 1; paddr = gaddr; end
    gcnt++; fcnt++;
    fifo_full = (full_mode != 0) && (fcnt % 5 < 2);
    mem_gnt = mem_req && !pend && !mem_rvalid && (gnt_mode == 0 || gcnt % 3 != 1);
    if (mem_gnt) begin
      gaddr = mem_addr[9:2];
      if (n_acc < 64) acc_log[n_acc] = mem_addr;
      n_acc++;
    end
    #1;
    if (fifo_wr) begin
      if (fifo_full) begin
        n_fail++;
        $display("FAIL R9: write while full act=1 exp=0");
      end else begin
        if (n_fifo < 64) begin fd_log[n_fifo] = fifo_data; ft_log[n_fifo] = fifo_tag; end
        n_fifo++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [3:0] m, input bit ovr);
    logic [31:0] e_acc [64];
    logic [31:0] e_fd [64];
    int ea = 0, ef = 0, t = 0, bad_a = 0, bad_d = 0;
    bit seen = 0;
    for (int c = 0; c < 4; c++) begin
      if (m[c]) begin
        logic [31:0] p, pa;
        int cnt, nw;
        p = ptr_m[c];
        cnt = (int'(m) * 3 + c * 5) % 11;
        pa = 32'd512 + 32'(c * 64);
        mem[p[9:2]] = {16'hBEEF, 16'(cnt)};
        mem[p[9:2] + 8'd1] = pa;
        e_acc[ea++] = p; e_acc[ea++] = p + 4;
        nw = (cnt + 3) / 4;
        for (int i = 0; i < nw; i++) begin
          e_acc[ea++] = pa + 32'(4 * i);
          e_fd[ef++] = mem[pa[9:2] + 8'(i)];
        end
        ptr_m[c] = p + 8;
      end
    end
    @(negedge clk);
    ctx_en = m; n_acc = 0; n_fifo = 0;
    cyc_start = 1;
    @(negedge clk);
    cyc_start = 0;
    if (ovr) begin
      repeat (4) @(negedge clk);
      cyc_start = 1;
      @(negedge clk);
      cyc_start = 0;
    end
    while (!seen && t < 3000) begin
      @(negedge clk);
      #2;
      t++;
      for (int k = 0; k < n_fifo && k < 64; k++) if (ft_log[k]) seen = 1;
    end
    chk(seen, "R8 marker written", 32'(seen), 1);
    chk(n_acc == ea, "R2/R3 access count", 32'(n_acc), 32'(ea));
    for (int k = 0; k < ea && k < n_acc; k++) if (acc_log[k] !== e_acc[k]) bad_a++;
    chk(bad_a == 0, "R5/R7 address sequence", 32'(bad_a), 0);
    chk(n_fifo == ef + 1, "R6 FIFO word count", 32'(n_fifo), 32'(ef + 1));
    for (int k = 0; k < ef && k < n_fifo; k++)
      if (fd_log[k] !== e_fd[k] || ft_log[k] !== 1'b0) bad_d++;
    chk(bad_d == 0, "R8/R9 payload stream", 32'(bad_d), 0);
    if (n_fifo == ef + 1)
      chk(fd_log[ef] === MARK && ft_log[ef] === 1'b1, "R8 marker word", fd_log[ef], MARK);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired act=timeout exp=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 ^ (32'(i) * 32'h0001_0103);
    repeat (3) @(negedge clk);
    chk(mem_req == 0 && fifo_wr == 0 && ovr_cnt == 0, "R1 reset idle",
        {mem_req, fifo_wr, ovr_cnt}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(mem_req == 0 && fifo_wr == 0, "R1 idle after reset", {mem_req, fifo_wr}, 0);
    for (int c = 0; c < 4; c++) begin
      ptr_load = 4'(1 << c); ptr_wdata = 32'(c * 128); ptr_m[c] = 32'(c * 128);
      @(negedge clk);
    end
    ptr_load = 0;
    for (int m = 0; m < 16; m++) begin
      gnt_mode = m % 2; lat = 1 + m % 3; full_mode = (m >= 8) ? 1 : 0;
      run_cycle(4'(m), 0);
    end
    chk(ovr_cnt == 0, "R10 no overrun yet", 32'(ovr_cnt), 0);
    // R7: reload pointer of context 2
    @(negedge clk);
    ptr_load = 4'b0100; ptr_wdata = 32'd960; ptr_m[2] = 32'd960;
    @(negedge clk);
    ptr_load = 0;
    gnt_mode = 1; lat = 2; full_mode = 1;
    run_cycle(4'b0100, 0);
    // R10: overrun during a busy cycle
    gnt_mode = 0; lat = 3; full_mode = 0;
    run_cycle(4'hF, 1);
    chk(ovr_cnt == 1, "R10 overrun counted", 32'(ovr_cnt), 1);
    n_acc = 0; n_fifo = 0;
    repeat (20) @(negedge clk);
    chk(n_acc == 0 && n_fifo == 0, "R10 no extra cycle", 32'(n_acc + n_fifo), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule